// File: doc/BRIEF.md
# Load/Store Port Protocol Monitor

This block is a passive observer that sits on one load/store request port, between an execution unit that issues requests and a memory buffer that serves them. It samples the port every clock and checks the handshake rules on both sides of it. It drives nothing on the port.

Each rule has its own sticky error bit, and a combined flag reports when any bit is set. The monitor follows each transaction with a small tracker:

- A request pulse opens a transaction.
- The address phase ends with either an acknowledge or an exception.
- A load closes on its data-valid pulse.
- A store closes one cycle after its data-valid pulse.

The monitor checks the busy line against this tracker. Busy must drop the cycle after a load completes or an exception arrives. For a store, busy must stay high for one more cycle after the data pulse and drop the cycle after that. While busy is high, the address must not change.

Data values, exception causes and the memory access itself are not checked. For that reason the data buses are not brought into the monitor. An abort input sends the tracker back to idle without raising an error. A synchronous clear input empties the error bits.

Top module: `ldst_port_monitor`

## Requirements
- R1: If the load request and the store request are high in the same cycle, bit 0 of errVec is set. No transaction is opened.
- R2: Busy must be high in every cycle of an open transaction, starting with the cycle after the request pulse. For a store this includes the cycle just after the store-data pulse. A low busy in any of these cycles sets bit 2.
- R3: A request pulse while a transaction is open, or while busy is high, sets bit 1.
- R4: Busy must be low in the cycle after a load-data pulse, after an address exception, and two cycles after a store-data pulse. A high busy in that cycle sets bit 3.
- R5: Within a transaction, once address-valid has been seen high, it must stay high and the address must not change until the transaction ends. A violation sets bit 4.
- R6: Address acknowledge and address exception high together set bit 5. The exception takes precedence and ends the transaction.
- R7: If acknowledge or exception is high for two cycles in a row, bit 6 is set. A second, separate acknowledge within the same transaction sets bit 7.
- R8: A load-data pulse longer than one cycle sets bit 8. A load-data pulse that starts before the address acknowledge, during a store, or outside a transaction sets bit 9.
- R9: A store-data pulse longer than one cycle sets bit 10. A store-data pulse that starts before the address acknowledge, during a load, or outside a transaction sets bit 11.
- R10: On a request cycle and throughout an open transaction, the transfer length must be 1, 2, 4 or 8. Any other value sets bit 12.
- R11: Error bits stay set until clrErr is sampled high. The cycle after that, errVec is all zero. errAny is high exactly when any bit of errVec is set.
- R12: An abort sampled high returns the tracker to idle and raises no error in that cycle. The next transaction is then checked normally.
- R13: After reset, errVec stays zero until the first request pulse, whatever the other port signals do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clrErr | input | 1 | Synchronous clear of all error bits |
| abortIn | input | 1 | Return the tracker to idle |
| ldReq | input | 1 | Load request pulse |
| stReq | input | 1 | Store request pulse |
| busy | input | 1 | Port busy from the buffer side |
| addrValid | input | 1 | Address valid flag |
| addr | input | ADDR_W | Request address |
| addrAck | input | 1 | Address acknowledge pulse |
| addrExc | input | 1 | Address exception pulse |
| ldValid | input | 1 | Load data valid pulse |
| stValid | input | 1 | Store data valid pulse |
| xferLen | input | LEN_W | Transfer length in bytes |
| errVec | output | 13 | Sticky error bits, one per rule |
| errAny | output | 1 | OR of all error bits |

## Verification
Clean loads, clean stores at every legal length, and a load that ends in an exception must all leave errVec at zero. This shows that the monitor accepts all three legal ways a transaction can end.

Each faulty pattern breaks exactly one rule, and the bench checks that only the expected single bit is set. The faulty patterns are:
- busy that never rises, or that falls one cycle early on a store;
- busy that stays high one cycle too long;
- an address that drifts, or whose valid flag drops;
- clashing, stretched or repeated acknowledges;
- data pulses that are stretched or come too early;
- a request that overlaps an open transaction;
- an illegal length.

Isolating each bit this way separates pulse-width faults from ordering faults.

Abort, sticky hold with clear, and traffic before the first request confirm that the monitor stays quiet where the rules exempt it.

// File: rtl/ldst_mon_pkg.sv
`timescale 1ns/1ps
package ldst_mon_pkg;

  localparam int NUM_ERR = 13;

  localparam int E_BOTH_REQ   = 0;
  localparam int E_OVERLAP    = 1;
  localparam int E_BUSY_HOLD  = 2;
  localparam int E_BUSY_REL   = 3;
  localparam int E_ADDR_HOLD  = 4;
  localparam int E_ACK_CLASH  = 5;
  localparam int E_ACK_WIDTH  = 6;
  localparam int E_ACK_REPEAT = 7;
  localparam int E_LD_WIDTH   = 8;
  localparam int E_LD_STRAY   = 9;
  localparam int E_ST_WIDTH   = 10;
  localparam int E_ST_STRAY   = 11;
  localparam int E_LEN        = 12;

  typedef enum logic [2:0] {
    TR_IDLE,
    TR_LD_ADDR,
    TR_LD_DATA,
    TR_ST_ADDR,
    TR_ST_DATA,
    TR_ST_HOLD
  } trackState_e;

  // strobes from the tracker to the rule datapath
  typedef struct packed {
    logic armed;      // a request has been seen since reset
    logic active;     // a transaction is open
    logic ldData;     // load acknowledged, awaiting load data
    logic stData;     // store acknowledged, awaiting store data
    logic stHold;     // cycle after the store data pulse
    logic expectLow;  // busy must be low this cycle
    logic quiet;      // abort: suppress all checks
  } monStrobes_t;

endpackage

// File: rtl/ldst_mon_ctrl.sv
`timescale 1ns/1ps
module ldst_mon_ctrl
  import ldst_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        abortIn,
  input  logic        ldReq,
  input  logic        stReq,
  input  logic        addrAck,
  input  logic        addrExc,
  input  logic        ldValid,
  input  logic        stValid,
  output monStrobes_t strobes
);

  trackState_e stateQ, stateNext;
  logic        expectQ, expectNext;
  logic        armedQ;

  always_comb begin
    stateNext  = stateQ;
    expectNext = 1'b0;
    if (abortIn) begin
      stateNext = TR_IDLE;
    end else begin
      case (stateQ)
        TR_IDLE: begin
          if (ldReq && !stReq)      stateNext = TR_LD_ADDR;
          else if (stReq && !ldReq) stateNext = TR_ST_ADDR;
        end
        TR_LD_ADDR: begin
          if (addrExc) begin
            stateNext  = TR_IDLE;
            expectNext = 1'b1;
          end else if (addrAck) begin
            stateNext = TR_LD_DATA;
          end
        end
        TR_LD_DATA: begin
          if (ldValid) begin
            stateNext  = TR_IDLE;
            expectNext = 1'b1;
          end
        end
        TR_ST_ADDR: begin
          if (addrExc) begin
            stateNext  = TR_IDLE;
            expectNext = 1'b1;
          end else if (addrAck) begin
            stateNext = TR_ST_DATA;
          end
        end
        TR_ST_DATA: begin
          if (stValid) stateNext = TR_ST_HOLD;
        end
        TR_ST_HOLD: begin
          stateNext  = TR_IDLE;
          expectNext = 1'b1;
        end
        default: stateNext = TR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= TR_IDLE;
      expectQ <= 1'b0;
      armedQ  <= 1'b0;
    end else begin
      stateQ  <= stateNext;
      expectQ <= expectNext;
      if (ldReq || stReq) armedQ <= 1'b1;
    end
  end

  always_comb begin
    strobes.armed     = armedQ;
    strobes.active    = (stateQ != TR_IDLE);
    strobes.ldData    = (stateQ == TR_LD_DATA);
    strobes.stData    = (stateQ == TR_ST_DATA);
    strobes.stHold    = (stateQ == TR_ST_HOLD);
    strobes.expectLow = expectQ;
    strobes.quiet     = abortIn;
  end

  // R12: abort leaves the tracker idle with no pending release check
  a_r12_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    abortIn |=> (!strobes.active && !strobes.expectLow));

  // R4: the cycle after the store hold cycle demands a low busy
  a_r4_store_release: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stHold && !abortIn) |=> strobes.expectLow);

  // R4: a load data pulse closes the transaction
  a_r4_load_release: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ldData && ldValid && !abortIn) |=> (strobes.expectLow && !strobes.active));

  // R13: once armed, the monitor stays armed
  a_r13_armed_keep: assert property (@(posedge clk) disable iff (!rstN)
    strobes.armed |=> strobes.armed);

endmodule

// File: rtl/ldst_mon_errs.sv
`timescale 1ns/1ps
module ldst_mon_errs
  import ldst_mon_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int LEN_W     = 4,
  parameter int MAX_BYTES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clrErr,
  input  monStrobes_t        strobes,
  input  logic               ldReq,
  input  logic               stReq,
  input  logic               busy,
  input  logic               addrValid,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               addrAck,
  input  logic               addrExc,
  input  logic               ldValid,
  input  logic               stValid,
  input  logic [LEN_W-1:0]   xferLen,
  output logic [NUM_ERR-1:0] errVec
);

  logic [ADDR_W-1:0]  addrQ;
  logic               addrHeldQ;
  logic               ackPrevQ, ldPrevQ, stPrevQ;
  logic [NUM_ERR-1:0] errQ;
  logic [NUM_ERR-1:0] hit;
  logic               chk, reqAny, ackAny, lenOk, postAck;

  assign chk     = !strobes.quiet;
  assign reqAny  = ldReq | stReq;
  assign ackAny  = addrAck | addrExc;
  assign postAck = strobes.ldData | strobes.stData | strobes.stHold;
  assign lenOk   = ($countones(xferLen) == 1) && (int'(xferLen) <= MAX_BYTES);

  always_comb begin
    hit               = '0;
    hit[E_BOTH_REQ]   = ldReq & stReq;
    hit[E_OVERLAP]    = reqAny & (strobes.active | busy);
    hit[E_BUSY_HOLD]  = strobes.active & !busy;
    hit[E_BUSY_REL]   = strobes.expectLow & busy;
    hit[E_ADDR_HOLD]  = strobes.active & addrHeldQ & (!addrValid || (addr != addrQ));
    hit[E_ACK_CLASH]  = strobes.armed & addrAck & addrExc;
    hit[E_ACK_WIDTH]  = strobes.armed & ackAny & ackPrevQ;
    hit[E_ACK_REPEAT] = ackAny & !ackPrevQ & postAck;
    hit[E_LD_WIDTH]   = strobes.armed & ldValid & ldPrevQ;
    hit[E_LD_STRAY]   = strobes.armed & ldValid & !ldPrevQ & !strobes.ldData;
    hit[E_ST_WIDTH]   = strobes.armed & stValid & stPrevQ;
    hit[E_ST_STRAY]   = strobes.armed & stValid & !stPrevQ & !strobes.stData;
    hit[E_LEN]        = (reqAny | strobes.active) & !lenOk;
    hit               = chk ? hit : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      addrHeldQ <= 1'b0;
      ackPrevQ  <= 1'b0;
      ldPrevQ   <= 1'b0;
      stPrevQ   <= 1'b0;
    end else begin
      ackPrevQ  <= ackAny;
      ldPrevQ   <= ldValid;
      stPrevQ   <= stValid;
      addrHeldQ <= chk & strobes.active & (addrHeldQ | addrValid);
      if (strobes.active && addrValid && !addrHeldQ) addrQ <= addr;
    end
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       errQ[i] <= 1'b0;
      else if (clrErr) errQ[i] <= 1'b0;
      else if (hit[i]) errQ[i] <= 1'b1;
    end
  end

  assign errVec = errQ;

  // R11: a clear empties every bit on the next cycle
  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrErr |=> (errVec == '0));

  // R11: without a clear no set bit is lost
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !clrErr |=> ((errVec & $past(errVec)) == $past(errVec)));

  // R13: nothing is reported before the first request
  a_r13_quiet_start: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.armed |-> (errVec == '0));

  // R5: the shadow address is only tracked inside a transaction
  a_r5_held_inside: assert property (@(posedge clk) disable iff (!rstN)
    addrHeldQ |-> $past(strobes.active));

endmodule

// File: rtl/ldst_port_monitor.sv
`timescale 1ns/1ps
module ldst_port_monitor
  import ldst_mon_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int LEN_W     = 4,
  parameter int MAX_BYTES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clrErr,
  input  logic               abortIn,
  input  logic               ldReq,
  input  logic               stReq,
  input  logic               busy,
  input  logic               addrValid,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               addrAck,
  input  logic               addrExc,
  input  logic               ldValid,
  input  logic               stValid,
  input  logic [LEN_W-1:0]   xferLen,
  output logic [NUM_ERR-1:0] errVec,
  output logic               errAny
);

  monStrobes_t strobes;

  ldst_mon_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .abortIn (abortIn),
    .ldReq   (ldReq),
    .stReq   (stReq),
    .addrAck (addrAck),
    .addrExc (addrExc),
    .ldValid (ldValid),
    .stValid (stValid),
    .strobes (strobes)
  );

  ldst_mon_errs #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .MAX_BYTES (MAX_BYTES)
  ) errs_i (
    .clk       (clk),
    .rstN      (rstN),
    .clrErr    (clrErr),
    .strobes   (strobes),
    .ldReq     (ldReq),
    .stReq     (stReq),
    .busy      (busy),
    .addrValid (addrValid),
    .addr      (addr),
    .addrAck   (addrAck),
    .addrExc   (addrExc),
    .ldValid   (ldValid),
    .stValid   (stValid),
    .xferLen   (xferLen),
    .errVec    (errVec)
  );

  assign errAny = |errVec;

endmodule

// File: tb/ldst_port_monitor_tb_top.sv
`timescale 1ns/1ps
module ldst_port_monitor_tb_top;

  localparam int AW = 16;
  localparam logic [12:0] M_BOTH = 13'h0001, M_OVL = 13'h0002, M_BHOLD = 13'h0004,
    M_BREL = 13'h0008, M_ADDR = 13'h0010, M_CLASH = 13'h0020, M_AWID = 13'h0040,
    M_AREP = 13'h0080, M_LWID = 13'h0100, M_LSTR = 13'h0200, M_SWID = 13'h0400,
    M_SSTR = 13'h0800, M_LEN = 13'h1000;

  logic clk = 1'b0, rstN = 1'b0, clrErr = 1'b0, abortIn = 1'b0;
  logic ldReq = 1'b0, stReq = 1'b0, busy = 1'b0, addrValid = 1'b0;
  logic addrAck = 1'b0, addrExc = 1'b0, ldValid = 1'b0, stValid = 1'b0;
  logic [AW-1:0] addr = 16'h0040;
  logic [3:0] xferLen = 4'd8;
  logic [12:0] errVec;
  logic errAny;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ldst_port_monitor #(.ADDR_W(AW), .LEN_W(4), .MAX_BYTES(8)) dut_i (
    .clk(clk), .rstN(rstN), .clrErr(clrErr), .abortIn(abortIn),
    .ldReq(ldReq), .stReq(stReq), .busy(busy), .addrValid(addrValid),
    .addr(addr), .addrAck(addrAck), .addrExc(addrExc), .ldValid(ldValid),
    .stValid(stValid), .xferLen(xferLen), .errVec(errVec), .errAny(errAny)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // order: ldReq stReq busy addrValid addrAck addrExc ldValid stValid
  task automatic drv(input logic lr, sr, b, av, ak, ex, lv, sv);
    ldReq = lr; stReq = sr; busy = b; addrValid = av;
    addrAck = ak; addrExc = ex; ldValid = lv; stValid = sv;
    cyc();
  endtask

  task automatic checkErr(input logic [12:0] m, input string tag);
    checks++;
    if (errVec !== m || errAny !== (m != 13'h0)) begin
      errors++;
      $display("FAIL %s errVec=%h errAny=%b expected errVec=%h errAny=%b",
               tag, errVec, errAny, m, (m != 13'h0));
    end
  endtask

  task automatic fresh();
    abortIn = 1'b0; xferLen = 4'd8; addr = 16'h0040;
    drv(0,0,0,0,0,0,0,0);
    clrErr = 1'b1; cyc(); clrErr = 1'b0;
  endtask

  task automatic cleanLoad();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,1,0); drv(0,0,0,0,0,0,0,0); cyc();
  endtask

  task automatic cleanStore();
    drv(0,1,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,0,0,0,1); drv(0,0,1,1,0,0,0,0);
    drv(0,0,0,0,0,0,0,0); cyc();
  endtask

  task automatic t_reset_quiet();
    checkErr(13'h0, "R11 reset state");
    drv(0,0,1,0,1,0,0,0); drv(0,0,1,1,1,1,1,1); drv(0,0,0,0,0,1,1,1);
    drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(13'h0, "R13 traffic before first request");
  endtask

  task automatic t_clean();
    fresh(); cleanLoad(); checkErr(13'h0, "R2 R4 R8 clean load");
    for (int i = 0; i < 4; i++) begin
      fresh(); xferLen = 4'(1 << i); cleanStore();
      checkErr(13'h0, $sformatf("R10 R9 clean store len %0d", 1 << i));
    end
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,0,1,0,0);
    drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(13'h0, "R4 clean exception");
  endtask

  task automatic t_both_sticky();
    fresh(); drv(1,1,0,0,0,0,0,0); cyc();
    checkErr(M_BOTH, "R1 both requests");
    repeat (3) cyc();
    checkErr(M_BOTH, "R11 sticky hold");
    clrErr = 1'b1; cyc(); clrErr = 1'b0;
    checkErr(13'h0, "R11 clear");
  endtask

  task automatic t_busy();
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,0,1,0,0,0,0); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,1,0); drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_BHOLD, "R2 busy not raised");
    fresh();
    drv(0,1,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,0,1); drv(0,0,0,1,0,0,0,0); drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_BHOLD, "R2 store early release");
    fresh();
    drv(0,1,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,0,1); drv(0,0,1,1,0,0,0,0); drv(0,0,1,0,0,0,0,0);
    drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_BREL, "R4 store late release");
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,1,0); drv(0,0,1,0,0,0,0,0); drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_BREL, "R4 load late release");
  endtask

  task automatic t_overlap();
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(1,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,1,0); drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_OVL, "R3 request during transaction");
  endtask

  task automatic t_addr();
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0);
    addr = 16'h0048; drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,1,0); drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_ADDR, "R5 address changed");
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,0,1,0,0,0);
    drv(0,0,1,1,0,0,1,0); drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_ADDR, "R5 address valid dropped");
  endtask

  task automatic t_ack();
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,1,1,0,0);
    drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_CLASH, "R6 acknowledge with exception");
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,1,0,0,0); drv(0,0,1,1,0,0,1,0); drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_AWID, "R7 acknowledge two cycles");
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,1,0,0,0); drv(0,0,1,1,0,0,1,0);
    drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_AREP, "R7 second acknowledge");
  endtask

  task automatic t_data();
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,1,0); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,1,0); drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_LSTR, "R8 load data before acknowledge");
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,1,0); drv(0,0,0,0,0,0,1,0); drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_LWID, "R8 load data two cycles");
    fresh();
    drv(0,1,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,1); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,0,1); drv(0,0,1,1,0,0,0,0); drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_SSTR, "R9 store data before acknowledge");
    fresh();
    drv(0,1,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0); drv(0,0,1,1,1,0,0,0);
    drv(0,0,1,1,0,0,0,1); drv(0,0,1,1,0,0,0,1); drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(M_SWID, "R9 store data two cycles");
  endtask

  task automatic t_len();
    fresh(); xferLen = 4'd3; cleanLoad();
    checkErr(M_LEN, "R10 length 3");
    fresh(); xferLen = 4'd0; cleanStore();
    checkErr(M_LEN, "R10 length 0");
  endtask

  task automatic t_abort();
    fresh();
    drv(1,0,0,0,0,0,0,0); drv(0,0,1,1,0,0,0,0);
    abortIn = 1'b1; drv(0,0,1,1,0,0,0,0); abortIn = 1'b0;
    drv(0,0,0,0,0,0,0,0); cyc();
    checkErr(13'h0, "R12 abort mid transaction");
    cleanLoad();
    checkErr(13'h0, "R12 load after abort");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    cyc();
    t_reset_quiet();
    t_clean();
    t_both_sticky();
    t_busy();
    t_overlap();
    t_addr();
    t_ack();
    t_data();
    t_len();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule